// File: doc/BRIEF.md
# SPI Register Command Slave

This block is an SPI slave front end that takes byte commands from a host and gives read access to a small bank of internal registers. The host frames each transaction with an active-low select. Within a frame it sends a command byte and then the bytes that command needs. The block decodes two commands. The first returns the value of one register. The second picks whether bytes travel with the most significant bit first or the least significant bit first.

The register bank sits behind a simple port. The block drives an address and a one-cycle read strobe, and the bank answers with combinational read data. SCK, MOSI and the select are synchronized into the system clock domain, and the system clock must run at least four times faster than SCK. The bus uses SPI mode 0. MOSI is sampled on the rising SCK edge and MISO changes after the falling edge. MISO is modelled as a data bit plus an output enable that a pad turns into a tri-state driver.

Top module: `spi_regcmd_slave`

## Requirements
- R1: The byte 0x21 in the command slot starts a read. The next byte is the register address, and its low ADDR_W bits appear on reg_addr_o while reg_rd_o is high.
- R2: A read has one filler byte after the address byte. Its value has no effect on the address or on the data returned.
- R3: Each read raises reg_rd_o for exactly one system clock cycle, when the filler byte completes. The reg_rdata_i value in that cycle is shifted out on MISO in the next byte slot.
- R4: The byte 0x18 in the command slot starts an order setting. A following byte of 0x81 selects LSB-first (bit 0 on the wire first). A following byte of 0x42 selects MSB-first (bit 7 on the wire first).
- R5: MISO carries 0 in every command, address, filler and configuration byte slot.
- R6: A new bit order takes effect from the first byte after the configuration byte. It applies to received command bytes and to transmitted data alike.
- R7: Any configuration byte other than 0x81 or 0x42 leaves the bit order unchanged.
- R8: An unknown command byte makes the block ignore the rest of the frame. It gives no read strobe and MISO stays 0 until the select is deasserted.
- R9: While nss_i is high, miso_en_o is 0 and the parser is idle. A command cut off by nss_i rising is dropped, and the next frame starts with a command byte.
- R10: After a read or an order setting completes, the next byte in the same frame is decoded as a new command.
- R11: After reset the order is MSB-first, miso_en_o is 0 and reg_rd_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| nss_i | input | 1 | Slave select, active low |
| sck_i | input | 1 | SPI serial clock, mode 0 |
| mosi_i | input | 1 | Serial data from the host |
| miso_o | output | 1 | Serial data to the host |
| miso_en_o | output | 1 | MISO output enable; 0 means high-impedance |
| reg_addr_o | output | ADDR_W | Register address |
| reg_rd_o | output | 1 | Read strobe, one cycle |
| reg_rdata_i | input | 8 | Register read data, valid in the strobe cycle |

## Verification
Random frames mix reads that use random addresses and random filler bytes with order settings that use 0x81, 0x42 or a random byte. A per-address data pattern exposes a wrong address or a stale value. Varying the filler shows that it is ignored. Because the order flips at random between reads, a data byte or command byte sent in the wrong bit order cannot decode correctly. Directed frames cover an unknown command followed by a valid read in the same frame, a read cut short by the select, and chained commands in one frame. These tell true discard and abort behaviour apart from a parser that simply resynchronises.

// File: rtl/spi_regcmd_pkg.sv
package spi_regcmd_pkg;
  localparam logic [7:0] OP_READ    = 8'h21;
  localparam logic [7:0] OP_ORDER   = 8'h18;
  localparam logic [7:0] ORDER_LSB  = 8'h81;
  localparam logic [7:0] ORDER_MSB  = 8'h42;

  typedef enum logic [2:0] {
    ST_CMD,
    ST_ADDR,
    ST_FILL,
    ST_DATA,
    ST_CFG,
    ST_DROP
  } cmd_state_e;
endpackage

// File: rtl/spi_sync_edge.sv
module spi_sync_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic nss_i,
  input  logic sck_i,
  input  logic mosi_i,
  output logic sel_o,
  output logic rise_o,
  output logic fall_o,
  output logic mosi_o
);
  logic [STAGES-1:0] nss_p, sck_p, mosi_p;
  logic              sck_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      nss_p  <= '1;
      sck_p  <= '0;
      mosi_p <= '0;
      sck_d  <= 1'b0;
    end else begin
      nss_p  <= {nss_p[STAGES-2:0], nss_i};
      sck_p  <= {sck_p[STAGES-2:0], sck_i};
      mosi_p <= {mosi_p[STAGES-2:0], mosi_i};
      sck_d  <= sck_p[STAGES-1];
    end
  end

  assign sel_o  = ~nss_p[STAGES-1];
  assign rise_o = sel_o & sck_p[STAGES-1] & ~sck_d;
  assign fall_o = sel_o & ~sck_p[STAGES-1] & sck_d;
  assign mosi_o = mosi_p[STAGES-1];
endmodule

// File: rtl/spi_byte_shifter.sv
module spi_byte_shifter #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         sel_i,
  input  logic         rise_i,
  input  logic         fall_i,
  input  logic         mosi_i,
  input  logic         lsb_first_i,
  input  logic         load_i,
  input  logic [W-1:0] load_data_i,
  output logic         done_o,
  output logic [W-1:0] rx_o,
  output logic         miso_o
);
  localparam int unsigned CW = $clog2(W);

  logic [CW-1:0] bit_cnt;
  logic [W-1:0]  rx_sr, rx_next, tx_sr;
  logic          last_bit;

  assign last_bit = (bit_cnt == CW'(W-1));
  assign rx_next  = lsb_first_i ? {mosi_i, rx_sr[W-1:1]} : {rx_sr[W-2:0], mosi_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_cnt <= '0;
      rx_sr   <= '0;
      rx_o    <= '0;
      done_o  <= 1'b0;
    end else if (!sel_i) begin
      bit_cnt <= '0;
      rx_sr   <= '0;
      done_o  <= 1'b0;
    end else begin
      done_o <= rise_i & last_bit;
      if (rise_i) begin
        rx_sr   <= rx_next;
        bit_cnt <= last_bit ? '0 : bit_cnt + 1'b1;
        if (last_bit) rx_o <= rx_next;
      end
    end
  end

  // bit_cnt == 0 marks the slot start: the fall after the last rise must not shift
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_sr <= '0;
    end else if (!sel_i) begin
      tx_sr <= '0;
    end else if (load_i) begin
      tx_sr <= load_data_i;
    end else if (fall_i && bit_cnt != '0) begin
      tx_sr <= lsb_first_i ? {1'b0, tx_sr[W-1:1]} : {tx_sr[W-2:0], 1'b0};
    end
  end

  assign miso_o = lsb_first_i ? tx_sr[0] : tx_sr[W-1];
endmodule

// File: rtl/spi_cmd_fsm.sv
module spi_cmd_fsm
  import spi_regcmd_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              done_i,
  input  logic [7:0]        rx_i,
  output logic              lsb_first_o,
  output logic              rd_o,
  output logic [ADDR_W-1:0] addr_o,
  output cmd_state_e        state_o
);
  cmd_state_e st_q, st_d;
  logic       lsb_q, lsb_d;

  always_comb begin
    st_d  = st_q;
    lsb_d = lsb_q;
    if (done_i) begin
      unique case (st_q)
        ST_CMD: begin
          if (rx_i == OP_READ)       st_d = ST_ADDR;
          else if (rx_i == OP_ORDER) st_d = ST_CFG;
          else                       st_d = ST_DROP;
        end
        ST_ADDR: st_d = ST_FILL;
        ST_FILL: st_d = ST_DATA;
        ST_DATA: st_d = ST_CMD;
        ST_CFG: begin
          if (rx_i == ORDER_LSB)      lsb_d = 1'b1;
          else if (rx_i == ORDER_MSB) lsb_d = 1'b0;
          st_d = ST_CMD;
        end
        ST_DROP: st_d = ST_DROP;
        default: st_d = ST_CMD;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_CMD;
      lsb_q  <= 1'b0;
      addr_o <= '0;
    end else begin
      lsb_q <= lsb_d;
      st_q  <= sel_i ? st_d : ST_CMD;
      if (sel_i && done_i && st_q == ST_ADDR) addr_o <= rx_i[ADDR_W-1:0];
    end
  end

  assign rd_o        = sel_i & done_i & (st_q == ST_FILL);
  assign lsb_first_o = lsb_q;
  assign state_o     = st_q;
endmodule

// File: rtl/spi_regcmd_slave.sv
module spi_regcmd_slave
  import spi_regcmd_pkg::*;
#(
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              nss_i,
  input  logic              sck_i,
  input  logic              mosi_i,
  output logic              miso_o,
  output logic              miso_en_o,
  output logic [ADDR_W-1:0] reg_addr_o,
  output logic              reg_rd_o,
  input  logic [7:0]        reg_rdata_i
);
  localparam int unsigned BYTE_W = 8;

  logic              sel, sck_rise, sck_fall, mosi_s;
  logic              byte_done, lsb_first, tx_bit;
  logic [BYTE_W-1:0] rx_byte, tx_load;
  cmd_state_e        cmd_st;

  spi_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .nss_i  (nss_i),
    .sck_i  (sck_i),
    .mosi_i (mosi_i),
    .sel_o  (sel),
    .rise_o (sck_rise),
    .fall_o (sck_fall),
    .mosi_o (mosi_s)
  );

  // reload every slot: register data after the filler, zeros otherwise
  assign tx_load = reg_rd_o ? reg_rdata_i : '0;

  spi_byte_shifter #(.W(BYTE_W)) u_shift (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sel_i       (sel),
    .rise_i      (sck_rise),
    .fall_i      (sck_fall),
    .mosi_i      (mosi_s),
    .lsb_first_i (lsb_first),
    .load_i      (byte_done),
    .load_data_i (tx_load),
    .done_o      (byte_done),
    .rx_o        (rx_byte),
    .miso_o      (tx_bit)
  );

  spi_cmd_fsm #(.ADDR_W(ADDR_W)) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sel_i       (sel),
    .done_i      (byte_done),
    .rx_i        (rx_byte),
    .lsb_first_o (lsb_first),
    .rd_o        (reg_rd_o),
    .addr_o      (reg_addr_o),
    .state_o     (cmd_st)
  );

  assign miso_en_o = sel;
  assign miso_o    = sel & tx_bit;
endmodule

// File: rtl/spi_regcmd_chk.sv
module spi_regcmd_chk
  import spi_regcmd_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       miso_en_o,
  input logic       reg_rd_o,
  input logic       byte_done,
  input logic [7:0] rx_byte,
  input logic       lsb_first,
  input cmd_state_e cmd_st
);
  AST_RD_SINGLE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_rd_o |=> !reg_rd_o); // R3

  AST_RD_WHILE_SELECTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_rd_o |-> miso_en_o); // R9

  AST_IDLE_WHEN_DESELECTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !miso_en_o |=> cmd_st == ST_CMD); // R9

  AST_ORDER_AT_BYTE_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !byte_done |=> $stable(lsb_first)); // R6

  AST_ORDER_LEGAL_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(lsb_first) |->
      (lsb_first && $past(rx_byte) == ORDER_LSB) ||
      (!lsb_first && $past(rx_byte) == ORDER_MSB)); // R7

  AST_DROP_NO_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_st == ST_DROP |-> !reg_rd_o); // R8
endmodule

bind spi_regcmd_slave spi_regcmd_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .miso_en_o (miso_en_o),
  .reg_rd_o  (reg_rd_o),
  .byte_done (byte_done),
  .rx_byte   (rx_byte),
  .lsb_first (lsb_first),
  .cmd_st    (cmd_st)
);

// File: tb/spi_regcmd_slave_test.sv
`timescale 1ns/1ps
module spi_regcmd_slave_test;
  localparam int HALF = 80;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       nss = 1'b1, sck = 1'b0, mosi = 1'b0;
  logic       miso, miso_en, rd;
  logic [7:0] addr, rdata;

  int   checks = 0, errors = 0;
  int   rd_cnt = 0;
  logic [7:0] rd_addr = '0;
  bit   lsb_mode = 1'b0;
  bit   finished = 1'b0;

  always #5 clk = ~clk;

  function automatic logic [7:0] reg_model(input logic [7:0] a);
    return (a * 8'd29) ^ 8'h5A;
  endfunction

  assign rdata = reg_model(addr);

  spi_regcmd_slave uut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .nss_i       (nss),
    .sck_i       (sck),
    .mosi_i      (mosi),
    .miso_o      (miso),
    .miso_en_o   (miso_en),
    .reg_addr_o  (addr),
    .reg_rd_o    (rd),
    .reg_rdata_i (rdata)
  );

  always @(posedge clk) if (rd) begin
    rd_cnt  <= rd_cnt + 1;
    rd_addr <= addr;
  end

  task automatic check(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    rx = '0;
    for (int i = 0; i < 8; i++) begin
      int idx;
      idx = lsb_mode ? i : 7 - i;
      mosi = tx[idx];
      #HALF;
      rx[idx] = miso;
      sck = 1'b1;
      #HALF;
      sck = 1'b0;
    end
  endtask

  task automatic frame_open();
    nss = 1'b0;
    #HALF;
    check(miso_en == 1'b1, "R9", {7'd0, miso_en}, 8'h01);
  endtask

  task automatic frame_close();
    #HALF;
    nss = 1'b1;
    #HALF;
    check(miso_en == 1'b0, "R9", {7'd0, miso_en}, 8'h00);
  endtask

  // read inside an open frame
  task automatic do_read(input logic [7:0] a, input logic [7:0] filler);
    logic [7:0] r0, r1, r2, r3;
    int c0;
    c0 = rd_cnt;
    xfer(8'h21, r0);
    xfer(a, r1);
    xfer(filler, r2);
    check(r0 == 0 && r1 == 0 && r2 == 0, "R5", r0 | r1 | r2, 8'h00);
    xfer(8'h00, r3);
    check(r3 == reg_model(a), lsb_mode ? "R3 R6 data lsb" : "R3 data msb", r3, reg_model(a));
    check(rd_cnt == c0 + 1, "R3 strobe count", 8'(rd_cnt - c0), 8'h01);
    check(rd_addr == a, "R1 R2 address", rd_addr, a);
  endtask

  task automatic do_cfg(input logic [7:0] v);
    logic [7:0] r0, r1;
    xfer(8'h18, r0);
    xfer(v, r1);
    check(r0 == 0 && r1 == 0, "R5 cfg slots", r0 | r1, 8'h00);
    if (v == 8'h81) lsb_mode = 1'b1;
    else if (v == 8'h42) lsb_mode = 1'b0;
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    int c0;
    void'($urandom(32'h5EED_1234));
    #40;
    check(miso_en == 1'b0 && rd == 1'b0, "R11 reset", {6'd0, miso_en, rd}, 8'h00);
    rst_n = 1'b1;
    #40;

    // R11: default MSB-first read
    frame_open(); do_read(8'h3C, 8'hFF); frame_close();
    // R2: same address, different filler
    frame_open(); do_read(8'h3C, 8'h00); frame_close();

    // R4: switch to LSB, read back
    frame_open(); do_cfg(8'h81); frame_close();
    frame_open(); do_read(8'hA7, 8'h5A); frame_close();

    // R7: illegal code keeps LSB
    frame_open(); do_cfg(8'h24); frame_close();
    frame_open(); do_read(8'h12, 8'h81); frame_close();

    // R10 R6: config then read in the same frame, order switches mid-frame
    frame_open(); do_cfg(8'h42); do_read(8'h81, 8'h18); frame_close();

    // R8: unknown command discards the frame
    c0 = rd_cnt;
    frame_open();
    xfer(8'h55, r);
    xfer(8'h21, r); xfer(8'h10, r); xfer(8'h00, r); xfer(8'h00, r);
    check(r == 8'h00, "R8 miso", r, 8'h00);
    check(rd_cnt == c0, "R8 no strobe", 8'(rd_cnt - c0), 8'h00);
    xfer(8'h18, r); xfer(8'h81, r);
    frame_close();
    check(lsb_mode == 1'b0, "R8 order kept", 8'(lsb_mode), 8'h00);
    frame_open(); do_read(8'h10, 8'hEE); frame_close();

    // R9: abort after address, next frame starts clean
    c0 = rd_cnt;
    frame_open(); xfer(8'h21, r); xfer(8'h44, r); frame_close();
    check(rd_cnt == c0, "R9 aborted read", 8'(rd_cnt - c0), 8'h00);
    frame_open(); do_read(8'h66, 8'h21); frame_close();
    // R9: abort mid-byte
    frame_open(); xfer(8'h18, r);
    mosi = 1'b1; #HALF; sck = 1'b1; #HALF; sck = 1'b0;
    frame_close();
    frame_open(); do_read(8'h07, 8'h42); frame_close();

    // random mix
    for (int n = 0; n < 40; n++) begin
      int kind;
      kind = $urandom_range(0, 3);
      frame_open();
      if (kind == 0) do_cfg(($urandom_range(0, 1) != 0) ? 8'h81 : 8'h42);
      else if (kind == 1) do_cfg(8'($urandom));
      do_read(8'($urandom), 8'($urandom));
      frame_close();
    end

    finished = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule